// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block decides, once per instruction, whether the processor should leave the running program to service a device. Each of up to eight devices has a ready flag and an enable flag. Each device also has a fixed 3-bit urgency level, set by parameter. Level 7 is the most urgent and level 0 the least. A device is counted as requesting only while both of its flags are high. Among the requesting devices, the block finds the one with the highest level. It then compares that level with the level at which the processor is currently running.

The comparison is acted on only in the cycle in which the processor marks the boundary between finishing one instruction and fetching the next. If the winning level is strictly above the running level, the block raises a single-cycle take pulse. In that same cycle it presents the winner's device index and level, which the sequencer uses to begin interrupt entry. If no request qualifies, nothing is signalled and the processor fetches the next instruction as usual. The index and level outputs keep their last captured values until the next taken interrupt.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `takeIrq` is 0, `winIdx` is 0 and `winLevel` is 0.
- R2: Device i takes part in arbitration only when both `devReady[i]` and `devIntEn[i]` are 1; a device with just one of the two set never wins.
- R3: Among the requesting devices, the winner is the one whose level (bits `DEV_LEVELS[3i+2:3i]` for device i) is highest.
- R4: When several requesting devices share the highest level, the one with the smallest index wins.
- R5: An interrupt is taken only if the winner's level is strictly greater than `curLevel`; a winner equal to `curLevel` is not taken.
- R6: A request whose level is below `curLevel` is never taken, and with `curLevel` = 7 nothing is ever taken.
- R7: A decision is made only on a clock edge where `boundary` is 1; with `boundary` low, `takeIrq` stays 0 and `winIdx`/`winLevel` do not change, whatever the requests do.
- R8: After a qualifying boundary edge, `takeIrq` is 1 for exactly the following cycle, and `winIdx` and `winLevel` show the winner in that same cycle; `takeIrq` falls the next cycle even if the request persists.
- R9: A boundary edge with no qualifying request leaves `winIdx` and `winLevel` at their previous values.
- R10: Device levels come from the `DEV_LEVELS` parameter; a device at level 0 can never interrupt, since no `curLevel` is below 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| devReady | input | 8 | Per-device ready flags |
| devIntEn | input | 8 | Per-device interrupt enable flags |
| curLevel | input | 3 | Priority level of the running program |
| boundary | input | 1 | High for one cycle at the execute-to-fetch boundary |
| takeIrq | output | 1 | One-cycle pulse: take the interrupt |
| winIdx | output | 3 | Index of the winning device |
| winLevel | output | 3 | Level of the winning device |

## Verification
The single-cycle shape of the take pulse depends on `boundary` never being high on two back-to-back cycles. That holds because every instruction takes more than one cycle. The bench raises `boundary` for one cycle at a time, with at least one low cycle between strobes. The assertions relate each take to the requests and `curLevel` sampled on the preceding edge. For that reason the bench changes requests and level only on the falling clock edge. The default level table puts two devices at level 3 and two at level 7, so both tie cases are reachable.

// File: rtl/irq_arbiter_pkg.sv
package irq_arbiter_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // load the winner into the output registers
    logic evalNow;  // boundary edge is being evaluated this cycle
  } arbStrobe_t;

endpackage

// File: rtl/irq_arbiter_dp.sv
module irq_arbiter_dp
  import irq_arbiter_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS = '0,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] devReady,
  input  logic [NUM_DEV-1:0] devIntEn,
  input  logic [LVL_W-1:0]   curLevel,
  input  arbStrobe_t         strobes,
  output logic               qualify,
  output logic [IDX_W-1:0]   winIdx,
  output logic [LVL_W-1:0]   winLevel
);

  logic [NUM_DEV-1:0] reqVec;
  logic [LVL_W-1:0]   devLevel [NUM_DEV];

  // Per-device request gating and level lookup.
  for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_dev
    assign reqVec[gi]   = devReady[gi] & devIntEn[gi];
    assign devLevel[gi] = DEV_LEVELS[gi*LVL_W +: LVL_W];
  end

  // Priority encoder: scan from the top index down so that an equal
  // level at a lower index replaces the current pick.
  logic               anyReq;
  logic [IDX_W-1:0]   bestIdx;
  logic [LVL_W-1:0]   bestLevel;

  always_comb begin
    anyReq    = 1'b0;
    bestIdx   = '0;
    bestLevel = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (reqVec[i] && (!anyReq || devLevel[i] >= bestLevel)) begin
        anyReq    = 1'b1;
        bestIdx   = IDX_W'(i);
        bestLevel = devLevel[i];
      end
    end
  end

  // Strict comparison against the running level.
  assign qualify = anyReq && (bestLevel > curLevel);

  // Output registers, loaded only on a taken interrupt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winIdx   <= '0;
      winLevel <= '0;
    end else if (strobes.capture) begin
      winIdx   <= bestIdx;
      winLevel <= bestLevel;
    end
  end

endmodule

// File: rtl/irq_arbiter_ctrl.sv
module irq_arbiter_ctrl
  import irq_arbiter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic       qualify,
  output arbStrobe_t strobes,
  output logic       takeIrq
);

  always_comb begin
    strobes.evalNow = boundary;
    strobes.capture = boundary & qualify;
  end

  // The pulse follows the capture edge and lasts one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) takeIrq <= 1'b0;
    else        takeIrq <= strobes.capture;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arbiter_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS =
    {3'd7, 3'd6, 3'd0, 3'd5, 3'd3, 3'd7, 3'd3, 3'd1},
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] devReady,
  input  logic [NUM_DEV-1:0] devIntEn,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic               boundary,
  output logic               takeIrq,
  output logic [IDX_W-1:0]   winIdx,
  output logic [LVL_W-1:0]   winLevel
);

  arbStrobe_t strobes;
  logic       qualify;

  irq_arbiter_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .qualify  (qualify),
    .strobes  (strobes),
    .takeIrq  (takeIrq)
  );

  irq_arbiter_dp #(
    .NUM_DEV    (NUM_DEV),
    .LVL_W      (LVL_W),
    .DEV_LEVELS (DEV_LEVELS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .devReady (devReady),
    .devIntEn (devIntEn),
    .curLevel (curLevel),
    .strobes  (strobes),
    .qualify  (qualify),
    .winIdx   (winIdx),
    .winLevel (winLevel)
  );

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS = '0,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] devReady,
  input logic [NUM_DEV-1:0] devIntEn,
  input logic [LVL_W-1:0]   curLevel,
  input logic               boundary,
  input logic               takeIrq,
  input logic [IDX_W-1:0]   winIdx,
  input logic [LVL_W-1:0]   winLevel
);

  // Requests and top level as seen on the previous edge.
  logic [NUM_DEV-1:0] prevReq;
  logic [LVL_W-1:0]   prevMax;
  logic [LVL_W-1:0]   curMax;

  always_comb begin
    curMax = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (devReady[i] && devIntEn[i] &&
          DEV_LEVELS[i*LVL_W +: LVL_W] > curMax)
        curMax = DEV_LEVELS[i*LVL_W +: LVL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevReq <= '0;
      prevMax <= '0;
    end else begin
      prevReq <= devReady & devIntEn;
      prevMax <= curMax;
    end
  end

  logic lowerTie;
  always_comb begin
    lowerTie = 1'b0;
    for (int j = 0; j < NUM_DEV; j++)
      if (IDX_W'(j) < winIdx && prevReq[j] &&
          DEV_LEVELS[j*LVL_W +: LVL_W] == winLevel)
        lowerTie = 1'b1;
  end

  // R2: the winner was requesting with both flags set
  a_r2_winner_requesting: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> prevReq[winIdx]);

  // R3: the winner had the highest requesting level
  a_r3_highest_level: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> (winLevel == prevMax));

  // R4: no lower index requested at the same level
  a_r4_low_index_tie: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> !lowerTie);

  // R5: the winning level strictly outranked the running level
  a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> (winLevel > $past(curLevel)));

  // R7: without a boundary edge nothing is taken and outputs hold
  a_r7_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> (!takeIrq && $stable(winIdx) && $stable(winLevel)));

  // R9: winner outputs change only together with a take pulse
  a_r9_hold_without_take: assert property (@(posedge clk) disable iff (!rst_n)
    !takeIrq |-> ($stable(winIdx) && $stable(winLevel)));

endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_DEV    (NUM_DEV),
  .LVL_W      (LVL_W),
  .DEV_LEVELS (DEV_LEVELS)
) u_chk (.*);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] devReady = '0;
  logic [7:0] devIntEn = '0;
  logic [2:0] curLevel = '0;
  logic       boundary = 1'b0;
  logic       takeIrq;
  logic [2:0] winIdx;
  logic [2:0] winLevel;

  int checks = 0;
  int fails  = 0;
  int lastIdx = 0;
  int lastLvl = 0;

  always #5 clk = ~clk;

  // Default level table: dev0=1 dev1=3 dev2=7 dev3=3 dev4=5 dev5=0 dev6=6 dev7=7
  irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .devReady(devReady), .devIntEn(devIntEn),
    .curLevel(curLevel), .boundary(boundary),
    .takeIrq(takeIrq), .winIdx(winIdx), .winLevel(winLevel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply one boundary strobe and check the cycle after it and the one after that.
  task automatic strobe(input string req, input logic [7:0] rdy, input logic [7:0] en,
                        input logic [2:0] lvl, input bit expTake,
                        input int expIdx, input int expLvl);
    @(negedge clk);
    devReady = rdy; devIntEn = en; curLevel = lvl; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    if (expTake) begin lastIdx = expIdx; lastLvl = expLvl; end
    chk(req, "take", int'(takeIrq), int'(expTake));
    chk(req, "idx", int'(winIdx), lastIdx);
    chk(req, "level", int'(winLevel), lastLvl);
    @(negedge clk);
    chk(req, "take after pulse", int'(takeIrq), 0);
    devReady = '0; devIntEn = '0;
  endtask

  task automatic testReset();
    chk("R1", "take in reset", int'(takeIrq), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "take", int'(takeIrq), 0);
    chk("R1", "idx", int'(winIdx), 0);
    chk("R1", "level", int'(winLevel), 0);
  endtask

  task automatic testGating();
    strobe("R2", 8'h04, 8'h00, 3'd0, 1'b0, 0, 0);
    strobe("R2", 8'h04, 8'h10, 3'd0, 1'b0, 0, 0);
    strobe("R2", 8'h00, 8'hFF, 3'd0, 1'b0, 0, 0);
    strobe("R2", 8'h04, 8'h04, 3'd0, 1'b1, 2, 7);
  endtask

  task automatic testPriority();
    strobe("R3", 8'h51, 8'h51, 3'd0, 1'b1, 6, 6);
    strobe("R3", 8'h13, 8'h13, 3'd2, 1'b1, 4, 5);
  endtask

  task automatic testTies();
    strobe("R4", 8'h0A, 8'h0A, 3'd0, 1'b1, 1, 3);
    strobe("R4", 8'h84, 8'h84, 3'd0, 1'b1, 2, 7);
    strobe("R4", 8'h80, 8'h80, 3'd0, 1'b1, 7, 7);
  endtask

  task automatic testStrict();
    strobe("R5", 8'h10, 8'h10, 3'd5, 1'b0, 0, 0);
    strobe("R9", 8'h10, 8'h10, 3'd5, 1'b0, 0, 0);
    strobe("R5", 8'h10, 8'h10, 3'd4, 1'b1, 4, 5);
  endtask

  task automatic testLower();
    strobe("R6", 8'h01, 8'h01, 3'd6, 1'b0, 0, 0);
    strobe("R6", 8'hFF, 8'hFF, 3'd7, 1'b0, 0, 0);
    strobe("R6", 8'hFF, 8'hFF, 3'd6, 1'b1, 2, 7);
  endtask

  task automatic testLevelZero();
    strobe("R10", 8'h20, 8'h20, 3'd0, 1'b0, 0, 0);
    strobe("R10", 8'h21, 8'h21, 3'd0, 1'b1, 0, 1);
  endtask

  task automatic testNoBoundary();
    @(negedge clk);
    devReady = 8'h40; devIntEn = 8'h40; curLevel = 3'd0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7", "take without boundary", int'(takeIrq), 0);
      chk("R7", "idx held", int'(winIdx), lastIdx);
      chk("R7", "level held", int'(winLevel), lastLvl);
    end
    devReady = '0; devIntEn = '0;
  endtask

  task automatic testPulse();
    @(negedge clk);
    devReady = 8'h40; devIntEn = 8'h40; curLevel = 3'd1; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk("R8", "take pulse", int'(takeIrq), 1);
    chk("R8", "idx in pulse", int'(winIdx), 6);
    chk("R8", "level in pulse", int'(winLevel), 6);
    lastIdx = 6; lastLvl = 6;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", "take low with request held", int'(takeIrq), 0);
    end
    devReady = '0; devIntEn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testGating();
    testPriority();
    testTies();
    testStrict();
    testLower();
    testLevelZero();
    testNoBoundary();
    testPulse();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule